// File: doc/BRIEF.md
# Byte and Word Register Bank with Stack Pointer

This block is the general register storage of an 8-bit processor datapath. It keeps six byte registers, named B, C, D, E, H and L, and a separate 16-bit stack pointer. The six bytes can be used one at a time, or as three 16-bit words: BC, DE and HL. In each word the first-named register is the high byte. Each cycle, a command input selects one operation. The operation can write a single byte, or it can act on a whole word: load it with a 16-bit immediate, increment it, decrement it, swap DE with HL, copy HL into the stack pointer, or add a word into HL.

All state changes happen on the rising clock edge. The word values and the byte read port are visible at the outputs at all times. HL always drives the memory address output, for operands reached through HL. A separate indirect-address output gives BC or DE, for accumulator loads and stores. The accumulator, the flags, instruction decode and memory access belong to other blocks.

The command is a 3-bit code: 0 idle, 1 byte write, 2 word load, 3 word increment, 4 word decrement, 5 DE/HL swap, 6 HL to stack pointer, 7 word add into HL. The word selector is 2 bits: 0 BC, 1 DE, 2 HL, 3 stack pointer. The byte selector is 3 bits: 0 B, 1 C, 2 D, 3 E, 4 H, 5 L. The codes 6 and 7 name no register.

Top module: `regpair_bank`

## Requirements
- R1: After an asynchronous active-low reset, all six byte registers, the stack pointer and the carry output are zero.
- R2: Byte write (command 1) loads the data byte into the register named by the byte selector (0 B, 1 C, 2 D, 3 E, 4 H, 5 L). The byte read output shows that register combinationally. With selector 6 or 7 a write changes nothing, and the read output is zero.
- R3: Word load (command 2) writes the 16-bit immediate into the word named by the word selector (0 BC, 1 DE, 2 HL, 3 stack pointer). For BC, DE and HL, bits 15:8 go to B, D or H and bits 7:0 go to C, E or L.
- R4: Word increment (command 3) and word decrement (command 4) change the selected word by one, modulo 65536, and leave the other words unchanged. They raise no carry: carryOut is 0 in the following cycle.
- R5: Word add (command 7) sets HL to HL plus the selected word (BC, DE, HL or stack pointer), truncated to 16 bits. carryOut is 1 in the following cycle exactly when the sum overflowed bit 15.
- R6: Swap (command 5) exchanges the full contents of DE and HL in a single cycle.
- R7: Copy (command 6) loads the stack pointer with HL and leaves HL unchanged.
- R8: memAddr always equals HL. indirAddr equals BC when indirSel is 0 and DE when indirSel is 1.
- R9: The idle command (0) changes no register, and carryOut is 0 in the cycle after any command other than word add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cmd | input | 3 | Operation code (0 to 7) |
| pairSel | input | 2 | Word selector: BC, DE, HL, stack pointer |
| regSel | input | 3 | Byte selector for write and read |
| wrData | input | 8 | Byte write data |
| immData | input | 16 | Immediate for word load |
| indirSel | input | 1 | Selects BC (0) or DE (1) on indirAddr |
| rdByte | output | 8 | Byte register named by regSel |
| bcOut | output | 16 | BC word |
| deOut | output | 16 | DE word |
| hlOut | output | 16 | HL word |
| spOut | output | 16 | Stack pointer |
| memAddr | output | 16 | Memory address, equal to HL |
| indirAddr | output | 16 | BC or DE as an indirect address |
| carryOut | output | 1 | Carry from bit 15 of the last word add |

## Verification
The assertions check the following on every cycle:
- a swap exchanges DE and HL;
- decrementing BC lowers it by exactly one;
- incrementing the stack pointer from all ones wraps it to zero;
- adding HL to itself gives a carry equal to the old HL bit 15;
- every command except word add leaves carryOut low;
- the copy loads the stack pointer from HL and leaves HL alone;
- the idle command freezes all state;
- the decoder never raises two strobes at once.

Some behaviour only the bench scenarios can show. These are the byte order within each word, what happens to the unnamed byte codes, the carry for each add operand over chosen values, and that a word operation leaves the other words untouched. The bench compares every output against an arithmetic model after each command.

// File: rtl/regpair_pkg.sv
package regpair_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE  = 3'd0,
    CMD_WRB   = 3'd1,
    CMD_LOADW = 3'd2,
    CMD_INCW  = 3'd3,
    CMD_DECW  = 3'd4,
    CMD_SWAP  = 3'd5,
    CMD_HLSP  = 3'd6,
    CMD_ADDW  = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    PAIR_BC = 2'd0,
    PAIR_DE = 2'd1,
    PAIR_HL = 2'd2,
    PAIR_SP = 2'd3
  } pair_e;

  localparam int NUM_BYTES = 6;

  typedef struct packed {
    logic       wrByte;
    logic       ldPair;
    logic       incPair;
    logic       decPair;
    logic       swapDeHl;
    logic       hlToSp;
    logic       addPair;
    pair_e      pairSel;
    logic [2:0] regSel;
  } strobe_t;

endpackage

// File: rtl/regpair_ctrl.sv
module regpair_ctrl
  import regpair_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] cmd,
  input  logic [1:0] pairSel,
  input  logic [2:0] regSel,
  output strobe_t    stb
);

  cmd_e cmdCode;
  assign cmdCode = cmd_e'(cmd);

  always_comb begin
    stb         = '0;
    stb.pairSel = pair_e'(pairSel);
    stb.regSel  = regSel;
    case (cmdCode)
      CMD_WRB:   stb.wrByte   = 1'b1;
      CMD_LOADW: stb.ldPair   = 1'b1;
      CMD_INCW:  stb.incPair  = 1'b1;
      CMD_DECW:  stb.decPair  = 1'b1;
      CMD_SWAP:  stb.swapDeHl = 1'b1;
      CMD_HLSP:  stb.hlToSp   = 1'b1;
      CMD_ADDW:  stb.addPair  = 1'b1;
      default:   ;
    endcase
  end

  // R9: at most one operation strobe per cycle
  assert_onehot_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrByte, stb.ldPair, stb.incPair, stb.decPair,
              stb.swapDeHl, stb.hlToSp, stb.addPair}));

endmodule

// File: rtl/regpair_dp.sv
module regpair_dp
  import regpair_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int PAIR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [PAIR_W-1:0] immData,
  input  logic              indirSel,
  output logic [BYTE_W-1:0] rdByte,
  output logic [PAIR_W-1:0] bcV,
  output logic [PAIR_W-1:0] deV,
  output logic [PAIR_W-1:0] hlV,
  output logic [PAIR_W-1:0] spQ,
  output logic [PAIR_W-1:0] indirAddr,
  output logic              carryQ
);

  // byte index: 0 B, 1 C, 2 D, 3 E, 4 H, 5 L
  logic [NUM_BYTES-1:0][BYTE_W-1:0] regQ, regD;
  logic [PAIR_W-1:0] spD;
  logic              carryD;
  logic [PAIR_W-1:0] opV;
  logic [PAIR_W-1:0] stepV;
  logic [PAIR_W:0]   sumV;

  assign bcV = {regQ[0], regQ[1]};
  assign deV = {regQ[2], regQ[3]};
  assign hlV = {regQ[4], regQ[5]};

  assign indirAddr = indirSel ? deV : bcV;
  assign rdByte    = (stb.regSel < 3'(NUM_BYTES)) ? regQ[stb.regSel] : '0;

  always_comb begin
    case (stb.pairSel)
      PAIR_BC: opV = bcV;
      PAIR_DE: opV = deV;
      PAIR_HL: opV = hlV;
      default: opV = spQ;
    endcase
  end

  // incrementer / decrementer path, independent of the add path
  always_comb begin
    if (stb.ldPair)       stepV = immData;
    else if (stb.incPair) stepV = opV + 1'b1;
    else                  stepV = opV - 1'b1;
  end

  assign sumV = {1'b0, hlV} + {1'b0, opV};

  always_comb begin
    regD   = regQ;
    spD    = spQ;
    carryD = 1'b0;
    if (stb.ldPair || stb.incPair || stb.decPair) begin
      case (stb.pairSel)
        PAIR_BC: {regD[0], regD[1]} = stepV;
        PAIR_DE: {regD[2], regD[3]} = stepV;
        PAIR_HL: {regD[4], regD[5]} = stepV;
        default: spD = stepV;
      endcase
    end
    if (stb.wrByte && (stb.regSel < 3'(NUM_BYTES))) begin
      regD[stb.regSel] = wrData;
    end
    if (stb.swapDeHl) begin
      {regD[2], regD[3]} = hlV;
      {regD[4], regD[5]} = deV;
    end
    if (stb.hlToSp) begin
      spD = hlV;
    end
    if (stb.addPair) begin
      {regD[4], regD[5]} = sumV[PAIR_W-1:0];
      carryD = sumV[PAIR_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regQ   <= '0;
      spQ    <= '0;
      carryQ <= 1'b0;
    end else begin
      regQ   <= regD;
      spQ    <= spD;
      carryQ <= carryD;
    end
  end

  // R6: swap exchanges DE and HL
  assert_swap_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.swapDeHl |=> (deV == $past(hlV)) && (hlV == $past(deV)));

  // R4: BC decrement lowers the word by one
  assert_dec_bc_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.decPair && stb.pairSel == PAIR_BC) |=> bcV == $past(bcV) - 1'b1);

  // R4: stack pointer increment wraps from all ones to zero
  assert_sp_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incPair && stb.pairSel == PAIR_SP && spQ == '1) |=> spQ == '0);

  // R5: HL doubled carries out its old top bit
  assert_double_carry_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.addPair && stb.pairSel == PAIR_HL) |=> carryQ == $past(hlV[PAIR_W-1]));

  // R9: no carry after any command other than word add
  assert_no_carry_R9: assert property (@(posedge clk) disable iff (!rstN)
    !stb.addPair |=> !carryQ);

  // R7: copy loads SP from HL and keeps HL
  assert_hl_to_sp_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.hlToSp |=> (spQ == $past(hlV)) && $stable(hlV));

  // R9: idle freezes all registers
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrByte || stb.ldPair || stb.incPair || stb.decPair ||
      stb.swapDeHl || stb.hlToSp || stb.addPair)
    |=> $stable(regQ) && $stable(spQ));

endmodule

// File: rtl/regpair_bank.sv
module regpair_bank
  import regpair_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int PAIR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cmd,
  input  logic [1:0]        pairSel,
  input  logic [2:0]        regSel,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [PAIR_W-1:0] immData,
  input  logic              indirSel,
  output logic [BYTE_W-1:0] rdByte,
  output logic [PAIR_W-1:0] bcOut,
  output logic [PAIR_W-1:0] deOut,
  output logic [PAIR_W-1:0] hlOut,
  output logic [PAIR_W-1:0] spOut,
  output logic [PAIR_W-1:0] memAddr,
  output logic [PAIR_W-1:0] indirAddr,
  output logic              carryOut
);

  strobe_t stb;

  regpair_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .pairSel (pairSel),
    .regSel  (regSel),
    .stb     (stb)
  );

  regpair_dp #(.BYTE_W(BYTE_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (wrData),
    .immData   (immData),
    .indirSel  (indirSel),
    .rdByte    (rdByte),
    .bcV       (bcOut),
    .deV       (deOut),
    .hlV       (hlOut),
    .spQ       (spOut),
    .indirAddr (indirAddr),
    .carryQ    (carryOut)
  );

  assign memAddr = hlOut;

endmodule

// File: tb/regpair_bank_tb.sv
`timescale 1ns/1ps
module regpair_bank_tb_top;

  localparam int CYC = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [1:0]  pairSel = 2'd0;
  logic [2:0]  regSel = 3'd0;
  logic [7:0]  wrData = 8'd0;
  logic [15:0] immData = 16'd0;
  logic        indirSel = 1'b0;
  logic [7:0]  rdByte;
  logic [15:0] bcOut, deOut, hlOut, spOut, memAddr, indirAddr;
  logic        carryOut;

  int checks = 0;
  int errors = 0;

  bit [7:0]  mb [6];
  bit [15:0] mSp;
  bit        mCarry;

  always #(CYC/2) clk = ~clk;

  regpair_bank dut_i (.*);

  task automatic check(string tag, string what, logic [16:0] act, logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit [15:0] mPair(int s);
    case (s)
      0: return {mb[0], mb[1]};
      1: return {mb[2], mb[3]};
      2: return {mb[4], mb[5]};
      default: return mSp;
    endcase
  endfunction

  function automatic void mSetPair(int s, bit [15:0] v);
    case (s)
      0: {mb[0], mb[1]} = v;
      1: {mb[2], mb[3]} = v;
      2: {mb[4], mb[5]} = v;
      default: mSp = v;
    endcase
  endfunction

  task automatic checkAll(string tag);
    check(tag, "bc", {1'b0, bcOut}, {1'b0, mPair(0)});
    check(tag, "de", {1'b0, deOut}, {1'b0, mPair(1)});
    check(tag, "hl", {1'b0, hlOut}, {1'b0, mPair(2)});
    check(tag, "sp", {1'b0, spOut}, {1'b0, mSp});
    check(tag, "carry", {16'd0, carryOut}, {16'd0, mCarry});
    check("R8", "memAddr", {1'b0, memAddr}, {1'b0, mPair(2)});
    for (int r = 0; r < 8; r++) begin
      regSel = 3'(r);
      #1;
      check("R2", "rdByte", {9'd0, rdByte}, {9'd0, (r < 6) ? mb[r] : 8'd0});
    end
    for (int s = 0; s < 2; s++) begin
      indirSel = s[0];
      #1;
      check("R8", "indirAddr", {1'b0, indirAddr}, {1'b0, mPair(s)});
    end
  endtask

  task automatic doCmd(int c, int ps, int rs, bit [7:0] wd, bit [15:0] imm, string tag);
    bit [16:0] sum;
    @(negedge clk);
    cmd = 3'(c); pairSel = 2'(ps); regSel = 3'(rs); wrData = wd; immData = imm;
    mCarry = 1'b0;
    case (c)
      1: if (rs < 6) mb[rs] = wd;
      2: mSetPair(ps, imm);
      3: mSetPair(ps, mPair(ps) + 16'd1);
      4: mSetPair(ps, mPair(ps) - 16'd1);
      5: begin
        bit [15:0] t;
        t = mPair(1);
        mSetPair(1, mPair(2));
        mSetPair(2, t);
      end
      6: mSp = mPair(2);
      7: begin
        sum = {1'b0, mPair(2)} + {1'b0, mPair(ps)};
        mSetPair(2, sum[15:0]);
        mCarry = sum[16];
      end
      default: ;
    endcase
    @(posedge clk);
    #2;
    cmd = 3'd0;
    @(negedge clk);
    checkAll(tag);
  endtask

  initial begin
    #(CYC * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) mb[i] = 8'd0;
    mSp = 16'd0;
    mCarry = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    checkAll("R1");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");

    // R2: byte writes over every selector code, several patterns
    for (int p = 0; p < 4; p++) begin
      for (int r = 0; r < 8; r++) begin
        doCmd(1, 0, r, 8'((r + 1) * 8'h25 ^ p * 8'h5a), 16'd0, "R2");
      end
    end

    // R3: word loads, byte order over all four words
    for (int s = 0; s < 4; s++) begin
      doCmd(2, s, 0, 8'd0, 16'h1234 + 16'(s) * 16'h1111, "R3");
      doCmd(2, s, 0, 8'd0, 16'hA55A ^ 16'(s << 12), "R3");
    end

    // R4: increment and decrement around every byte boundary
    for (int s = 0; s < 4; s++) begin
      foreach (mb[k]) ;
      doCmd(2, s, 0, 8'd0, 16'hFFFF, "R3");
      doCmd(3, s, 0, 8'd0, 16'd0, "R4");
      doCmd(4, s, 0, 8'd0, 16'd0, "R4");
      doCmd(2, s, 0, 8'd0, 16'h00FF, "R3");
      doCmd(3, s, 0, 8'd0, 16'd0, "R4");
      doCmd(4, s, 0, 8'd0, 16'd0, "R4");
      doCmd(2, s, 0, 8'd0, 16'h0000, "R3");
      doCmd(4, s, 0, 8'd0, 16'd0, "R4");
    end

    // R5: word add with every operand, carry and no-carry values
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 6; v++) begin
        bit [15:0] a, b;
        a = 16'(v * 16'h3579 + 16'h8001);
        b = 16'(v * 16'h2468 + 16'h7FFF);
        doCmd(2, 0, 0, 8'd0, 16'h0101 * 16'(v), "R3");
        doCmd(2, 1, 0, 8'd0, 16'hF00F ^ 16'(v), "R3");
        doCmd(2, 3, 0, 8'd0, b, "R3");
        doCmd(2, 2, 0, 8'd0, a, "R3");
        doCmd(7, s, 0, 8'd0, 16'd0, "R5");
        doCmd(0, 0, 0, 8'd0, 16'd0, "R9");
      end
    end

    // R6: swap
    doCmd(2, 1, 0, 8'd0, 16'hBEEF, "R3");
    doCmd(2, 2, 0, 8'd0, 16'h1357, "R3");
    doCmd(5, 0, 0, 8'd0, 16'd0, "R6");
    doCmd(5, 3, 0, 8'd0, 16'd0, "R6");

    // R7: HL to SP
    doCmd(6, 0, 0, 8'd0, 16'd0, "R7");
    doCmd(3, 2, 0, 8'd0, 16'd0, "R4");
    doCmd(6, 1, 0, 8'd0, 16'd0, "R7");

    // R9: idle with busy-looking operands changes nothing
    doCmd(0, 3, 4, 8'hFF, 16'hFFFF, "R9");
    doCmd(0, 2, 6, 8'h11, 16'h2222, "R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule